// File: doc/BRIEF.md
# Serial Register Access Port

This block is a four-wire serial slave that lets an external controller read and write a bank of internal configuration and status registers. The controller raises a frame enable, toggles a serial clock and shifts a frame into the data input. The first bit picks read or write, the next bits carry the register address and the last bits carry the write data. On a read, the port fetches the addressed register and shifts its value back on the data output, which drives the wire only while read data is being returned.

The input is sampled on rising serial-clock edges and the output is launched on falling edges, so a controller that samples on its own rising edge always sees settled data. Since the output is released outside the read-data phase and the enable acts as a device select, the clock and data lines can be bussed across several devices, and input and output can share one wire. The register file itself sits outside this block: the port presents an address, a one-cycle write strobe with write data, and takes back combinational read data.

Top module: `sport_access`

## Requirements
- R1: While rst_ni is low, the output enable and the write strobe are low; reset also clears the bit counter so the next frame starts at its first bit.
- R2: A frame is 16 rising edges with the enable high: bit 0 is the mode (1 = read, 0 = write), bits 1 to 7 are the address LSB first, bits 8 to 15 are the data LSB first.
- R3: A write frame raises reg_we_o for exactly one serial-clock cycle, starting at the 16th rising edge, with reg_addr_o and reg_wdata_o holding the frame's address and data.
- R4: On a read frame the register value is taken after the 7th address bit and driven from the following falling edge, LSB first, one bit per falling edge, so the controller sees data bit k on rising edge 8+k.
- R5: The output enable is high only during the 8 read-data bits of a read frame and falls on the falling edge after the 16th rising edge; it is never high during a write frame.
- R6: Dropping the enable before the 16th rising edge aborts the frame: no write strobe, the output enable falls at once, and the next frame starts from its mode bit.
- R7: While the enable is low, clock and data activity causes no write strobe and no output drive.
- R8: Rising edges after the 16th within one enable window are ignored: no second strobe and no output drive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ser_clk_i | input | 1 | Serial clock, data in on rising edge, data out on falling edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| frame_en_i | input | 1 | Active-high frame enable and device select |
| ser_din_i | input | 1 | Serial data input |
| ser_dout_o | output | 1 | Serial data output, valid while ser_dout_oe_o is high |
| ser_dout_oe_o | output | 1 | Output enable for the tristate pad |
| reg_addr_o | output | ADDR_W | Register address |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_wdata_o | output | DATA_W | Register write data |
| reg_rdata_i | input | DATA_W | Register read data for reg_addr_o |

## Verification
The assertions check on every cycle that the write strobe lasts one cycle and only follows a full frame, that the bit counter stays in range and clears when the enable drops, that the output never drives while a strobe is raised, and that the address is stable while read data is driven. Only the bench scenarios can show that the LSB-first bit order lands values at the right address, that read data reaches the controller on the correct rising edges, and that aborted frames and trailing bits leave the registers untouched.

// File: rtl/sport_pkg.sv
`timescale 1ns/1ps
package sport_pkg;

  typedef enum logic [1:0] {
    PH_MODE,
    PH_ADDR,
    PH_DATA,
    PH_DONE
  } sport_phase_e;

  function automatic sport_phase_e phase_of(input int unsigned cnt,
                                            input int unsigned aw,
                                            input int unsigned dw);
    if (cnt == 0)            return PH_MODE;
    else if (cnt <= aw)      return PH_ADDR;
    else if (cnt <= aw + dw) return PH_DATA;
    else                     return PH_DONE;
  endfunction

endpackage

// File: rtl/sport_rx.sv
`timescale 1ns/1ps
module sport_rx
  import sport_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  localparam int FRAME_LEN = 1 + ADDR_W + DATA_W,
  localparam int CNT_W = $clog2(FRAME_LEN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              din_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              rd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              we_o
);

  logic [CNT_W-1:0]  cnt_q;
  logic              rd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              we_q;
  sport_phase_e      phase;

  assign phase = phase_of(int'(cnt_q), ADDR_W, DATA_W);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      rd_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      we_q  <= 1'b0;
    end else begin
      we_q <= 1'b0;
      if (phase != PH_DONE) cnt_q <= cnt_q + 1'b1;
      unique case (phase)
        PH_MODE: rd_q    <= din_i;
        PH_ADDR: addr_q  <= {din_i, addr_q[ADDR_W-1:1]};
        PH_DATA: begin
          wdata_q <= {din_i, wdata_q[DATA_W-1:1]};
          if (cnt_q == CNT_W'(FRAME_LEN - 1) && !rd_q) we_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign cnt_o   = cnt_q;
  assign rd_o    = rd_q;
  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;
  assign we_o    = we_q;

  // R3: strobe only once the whole frame has been counted
  p_we_full_frame_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_q |-> (cnt_q == CNT_W'(FRAME_LEN)));
  // R3: strobe lasts a single cycle
  p_we_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_q |=> !we_q);
  // R6: enable low clears the frame position
  p_abort_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0));
  // R8: counter saturates at the frame length
  p_cnt_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(FRAME_LEN));

endmodule

// File: rtl/sport_tx.sv
`timescale 1ns/1ps
module sport_tx #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  localparam int FRAME_LEN = 1 + ADDR_W + DATA_W,
  localparam int CNT_W = $clog2(FRAME_LEN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              dout_o,
  output logic              oe_o
);

  localparam logic [CNT_W-1:0] LoadAt = CNT_W'(ADDR_W + 1);
  localparam logic [CNT_W-1:0] EndAt  = CNT_W'(FRAME_LEN);

  logic [DATA_W-1:0] sh_q;
  logic              dout_q;
  logic              oe_q;

  // launches on the falling edge, state comes from rising-edge registers only
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      dout_q <= 1'b0;
      oe_q   <= 1'b0;
    end else if (rd_i && cnt_i == LoadAt) begin
      sh_q   <= rdata_i >> 1;
      dout_q <= rdata_i[0];
      oe_q   <= 1'b1;
    end else if (rd_i && cnt_i > LoadAt && cnt_i < EndAt) begin
      sh_q   <= sh_q >> 1;
      dout_q <= sh_q[0];
    end else begin
      oe_q <= 1'b0;
    end
  end

  assign dout_o = dout_q;
  assign oe_o   = oe_q;

  // R5: drive only during a read data phase
  p_oe_read_only_r5: assert property (@(negedge clk_i) disable iff (!rst_ni)
    oe_q |-> rd_i);

endmodule

// File: rtl/sport_access.sv
`timescale 1ns/1ps
module sport_access #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              ser_clk_i,
  input  logic              rst_ni,
  input  logic              frame_en_i,
  input  logic              ser_din_i,
  output logic              ser_dout_o,
  output logic              ser_dout_oe_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic              reg_we_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);

  localparam int FRAME_LEN = 1 + ADDR_W + DATA_W;
  localparam int CNT_W = $clog2(FRAME_LEN + 1);

  logic [CNT_W-1:0] cnt;
  logic             rd;
  logic             oe_raw;

  sport_rx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rx (
    .clk_i   (ser_clk_i),
    .rst_ni  (rst_ni),
    .en_i    (frame_en_i),
    .din_i   (ser_din_i),
    .cnt_o   (cnt),
    .rd_o    (rd),
    .addr_o  (reg_addr_o),
    .wdata_o (reg_wdata_o),
    .we_o    (reg_we_o)
  );

  sport_tx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_tx (
    .clk_i   (ser_clk_i),
    .rst_ni  (rst_ni),
    .cnt_i   (cnt),
    .rd_i    (rd),
    .rdata_i (reg_rdata_i),
    .dout_o  (ser_dout_o),
    .oe_o    (oe_raw)
  );

  // release the pad the moment the device is deselected
  assign ser_dout_oe_o = oe_raw & frame_en_i;

  // R5: no drive while a write commits
  p_no_drive_on_write_r5: assert property (@(posedge ser_clk_i) disable iff (!rst_ni)
    reg_we_o |-> !ser_dout_oe_o);
  // R4: address held while read data goes out
  p_addr_stable_read_r4: assert property (@(posedge ser_clk_i) disable iff (!rst_ni)
    (oe_raw && $past(oe_raw)) |-> $stable(reg_addr_o));

endmodule

// File: tb/sport_access_bench.sv
`timescale 1ns/1ps
module sport_access_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       din = 1'b0;
  logic       dout, dout_oe, we;
  logic [6:0] addr;
  logic [7:0] wdata, rdata;

  logic [7:0] mem [128];
  logic [7:0] exp_mem [128];
  int checks = 0, errors = 0, we_cnt = 0, oe_bad = 0;
  logic [6:0] last_addr;
  logic [7:0] last_wdata;
  logic abort_oe;
  bit done = 0;

  always #4 clk = ~clk;

  sport_access u_sport_access (
    .ser_clk_i(clk), .rst_ni(rst_n), .frame_en_i(en), .ser_din_i(din),
    .ser_dout_o(dout), .ser_dout_oe_o(dout_oe), .reg_addr_o(addr),
    .reg_we_o(we), .reg_wdata_o(wdata), .reg_rdata_i(rdata)
  );

  function automatic logic [7:0] init_val(input int a);
    return 8'((a * 37 + 5) & 8'hFF);
  endfunction

  initial for (int i = 0; i < 128; i++) begin
    mem[i] = init_val(i);
    exp_mem[i] = init_val(i);
  end

  assign rdata = mem[addr];
  always @(posedge clk) if (we) mem[addr] <= wdata;
  always @(negedge clk) if (we) begin
    we_cnt++;
    last_addr = addr;
    last_wdata = wdata;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // rd: 1 = read; abort_at: bit index where enable drops (-1 none); extra: trailing bits
  task automatic frame(input logic rd, input logic [6:0] a, input logic [7:0] d,
                       input int abort_at, input int extra, output logic [7:0] q);
    logic [15:0] bits;
    bit aborted = 0;
    bits = {d, a, rd};
    q = '0;
    oe_bad = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); #1;
      if (i == abort_at) begin
        en = 0; #1;
        abort_oe = dout_oe;
        aborted = 1;
        break;
      end
      en = 1; din = bits[i];
      @(posedge clk); #1;
      if (rd && i >= 8) begin
        q[i-8] = dout;
        if (!dout_oe) oe_bad++;
      end else if (dout_oe) oe_bad++;
    end
    if (!aborted) begin
      for (int k = 0; k < extra; k++) begin
        @(negedge clk); #1;
        din = 1'($urandom);
        @(posedge clk); #1;
        if (dout_oe) oe_bad++;
      end
      @(negedge clk); #1;
      en = 0;
      if (!rd && abort_at < 0) exp_mem[a] = d;
    end
    @(posedge clk); @(posedge clk); #1;
  endtask

  initial begin
    logic [7:0] q;
    int base;
    void'($urandom(32'h5A17));
    repeat (3) @(posedge clk);
    #1;
    check("R1 oe in reset", 32'(dout_oe), 0);
    check("R1 we in reset", 32'(we), 0);
    rst_n = 1;
    repeat (2) @(posedge clk);

    base = we_cnt;
    frame(0, 7'h05, 8'hA5, -1, 0, q);
    check("R3 one strobe", we_cnt - base, 1);
    check("R2 strobe addr", 32'(last_addr), 32'h05);
    check("R2 strobe data", 32'(last_wdata), 32'hA5);
    check("R5 no oe on write", oe_bad, 0);
    frame(1, 7'h05, 8'h00, -1, 0, q);
    check("R4 read back", 32'(q), 32'hA5);
    check("R5 oe only data phase", oe_bad, 0);

    frame(0, 7'h7F, 8'h01, -1, 0, q);
    check("R2 top addr", 32'(last_addr), 32'h7F);
    frame(1, 7'h7F, 8'h00, -1, 4, q);
    check("R4 read top", 32'(q), 32'h01);
    check("R5 oe released after bit 16", oe_bad, 0);
    frame(1, 7'h01, 8'h00, -1, 0, q);
    check("R4 untouched reg", 32'(q), 32'(init_val(1)));

    base = we_cnt;
    frame(0, 7'h22, 8'h3C, -1, 5, q);
    check("R8 trailing bits one strobe", we_cnt - base, 1);
    check("R8 no drive on trailing", oe_bad, 0);

    base = we_cnt;
    frame(0, 7'h05, 8'hFF, 12, 0, q);
    check("R6 abort no write", we_cnt - base, 0);
    frame(1, 7'h05, 8'h00, 11, 0, q);
    check("R6 oe drops on abort", 32'(abort_oe), 0);
    frame(1, 7'h05, 8'h00, -1, 0, q);
    check("R6 value kept after abort", 32'(q), 32'hA5);

    base = we_cnt;
    oe_bad = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); #1;
      din = 1'($urandom);
      @(posedge clk); #1;
      if (dout_oe) oe_bad++;
    end
    check("R7 idle no strobe", we_cnt - base, 0);
    check("R7 idle no drive", oe_bad, 0);

    for (int n = 0; n < 80; n++) begin
      logic rd_r;
      logic [6:0] a_r;
      logic [7:0] d_r;
      rd_r = 1'($urandom);
      a_r = 7'($urandom);
      d_r = 8'($urandom);
      base = we_cnt;
      frame(rd_r, a_r, d_r, -1, 0, q);
      if (rd_r) check("R4 random read", 32'(q), 32'(exp_mem[a_r]));
      else check("R3 random write strobe", we_cnt - base, 1);
      check("R5 random oe window", oe_bad, 0);
    end

    rst_n = 0; en = 1; #1;
    check("R1 oe after reset", 32'(dout_oe), 0);
    en = 0;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule